// File: doc/BRIEF.md
# Two-Wire Serial Register Bank Slave

This block is an I2C slave. It gives a host controller access to a small bank of byte-wide registers. SCL and SDA are oversampled on the system clock. The block recognises start and stop conditions and compares the 7-bit device address with its own. After that it treats the first byte of a write as a pointer into the register bank. Later data bytes are written to the register the pointer selects, and the pointer then moves up by one. A read returns the register selected by the pointer. The pointer itself cannot be read.

A typical host sequence is: device address with write, pointer byte, repeated start, device address with read, then the data bytes.

Four registers at consecutive addresses together hold a 32-bit frequency word. The block copies that word to an output port only when all four bytes arrive in ascending order within one write burst. The block enforces the edges of the register map:
- A pointer value outside the map is refused.
- A write that runs off the top of the map is refused.
- A read that runs off the top keeps returning the highest register.

SDA is never driven high. The block only pulls the line low through an enable output.

Top module: `i2c_reg_bank`

## Requirements
- R1: The first byte after a start is 7 address bits, MSB first, then a direction bit (0 = write, 1 = read). When the 7 bits equal `DEV_ADDR`, the slave pulls SDA low during the 9th SCL pulse. Otherwise it leaves SDA released and ignores every bit until the next start.
- R2: In a write, the byte after the address loads the pointer. Each later byte is stored in the register the pointer selects, is acknowledged, and then the pointer increases by one.
- R3: A pointer byte with a value of `NUM_REGS` or more is not acknowledged. The slave returns to idle, no register is written, and further bytes in that transfer are not acknowledged.
- R4: A start or stop seen at any bit position ends the current transfer at once. No partly received byte is stored. After a start, the next byte is treated as a device address.
- R5: A write data byte that arrives when the pointer has already passed register `NUM_REGS-1` is discarded and not acknowledged, and the slave returns to idle.
- R6: After a start and a matching address with the direction bit set, the slave sends the register at the current pointer, MSB first, on SDA. After each byte the pointer moves up by one.
- R7: Once a read has passed the top of the map, every further byte returns register `NUM_REGS-1`. A byte that the host does not acknowledge ends the read, and the slave keeps SDA released afterwards.
- R8: `freqWord` is loaded with registers `FREQ_BASE`..`FREQ_BASE+3` (register `FREQ_BASE` in bits 7:0, `FREQ_BASE+3` in bits 31:24). This happens only when those four registers are written one after another, in ascending order, within one write burst.
- R9: A partial write to the frequency registers does not change `freqWord`. Neither does a write to them that starts partway through the group, or one that is split across separate transfers. The registers themselves still store the bytes.
- R10: After reset, every register reads 0, `freqWord` is 0 and SDA is released.
- R11: `sdaDriveLow` only ever pulls the line low, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the pin |
| sdaIn | input | 1 | Serial data line as seen on the pin (wired-AND value) |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| freqWord | output | 32 | Committed 32-bit frequency word |

## Verification
The tests write single bytes and multi-byte bursts at several pointer values. Each write is then read back with a repeated start, which separates a correct pointer increment from a stale or skipped register. Pointer bytes just inside and just outside the map, and bursts that straddle the top, show whether the slave stops acknowledging at the right byte. Reads that overrun the top show whether it repeats the last register instead of wrapping. Frequency-group bursts are sent complete, partial, starting partway through the group, split across transfers, and passing through the group from below. These patterns tell a commit tied to ordered burst writes apart from one triggered by any write to the top byte. Starts and stops in the middle of a byte check that the abort discards the partial byte but still accepts the next address.

// File: rtl/i2c_bank_pkg.sv
package i2c_bank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_RX,     // shifting in a byte from the host
    ST_ACK,    // holding SDA low through the ninth pulse
    ST_TX,     // shifting out a read byte
    ST_MACK    // sampling the host acknowledge after a read byte
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_t;

  // one-cycle requests from the protocol engine to the register datapath
  typedef struct packed {
    logic loadSub;    // accept received byte as the pointer
    logic writeData;  // store received byte at the pointer, then advance
    logic loadRead;   // a read byte is taken from the pointer, then advance
    logic busEvent;   // start or stop seen: any burst in progress ends
  } bankStrobe_t;

endpackage

// File: rtl/i2c_bank_ctrl.sv
module i2c_bank_ctrl
  import i2c_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        subValid,
  input  logic        ptrInRange,
  input  logic [7:0]  txByte,
  output logic [7:0]  rxByte,
  output bankStrobe_t strb,
  output logic        sdaDriveLow
);

  localparam int SYNC_LEN = 2;
  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] LAST_TX_BIT = 4'd7;

  logic [SYNC_LEN-1:0] sclSyncQ, sdaSyncQ;
  logic sclPrevQ, sdaPrevQ;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t stateQ, stateD;
  phase_t    phaseQ, phaseD;
  logic [3:0] bitCntQ, bitCntD;
  logic [7:0] rxQ, rxD, txQ, txD;
  logic readQ, readD, mAckQ, mAckD;

  // line synchronizers and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSyncQ <= '1;
      sdaSyncQ <= '1;
      sclPrevQ <= 1'b1;
      sdaPrevQ <= 1'b1;
    end else begin
      sclSyncQ <= {sclSyncQ[SYNC_LEN-2:0], sclIn};
      sdaSyncQ <= {sdaSyncQ[SYNC_LEN-2:0], sdaIn};
      sclPrevQ <= sclSyncQ[SYNC_LEN-1];
      sdaPrevQ <= sdaSyncQ[SYNC_LEN-1];
    end
  end

  assign sclNow   = sclSyncQ[SYNC_LEN-1];
  assign sdaNow   = sdaSyncQ[SYNC_LEN-1];
  assign sclRise  = sclNow & ~sclPrevQ;
  assign sclFall  = ~sclNow & sclPrevQ;
  assign startDet = sclNow & sclPrevQ & sdaPrevQ & ~sdaNow;
  assign stopDet  = sclNow & sclPrevQ & ~sdaPrevQ & sdaNow;

  always_comb begin
    stateD  = stateQ;
    phaseD  = phaseQ;
    bitCntD = bitCntQ;
    rxD     = rxQ;
    txD     = txQ;
    readD   = readQ;
    mAckD   = mAckQ;
    strb    = '0;
    if (stopDet) begin
      stateD        = ST_IDLE;
      strb.busEvent = 1'b1;
    end else if (startDet) begin
      stateD        = ST_RX;
      phaseD        = PH_ADDR;
      bitCntD       = '0;
      strb.busEvent = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: ;
        ST_RX: begin
          if (sclRise && bitCntQ != BYTE_BITS) begin
            rxD     = {rxQ[6:0], sdaNow};
            bitCntD = bitCntQ + 4'd1;
          end else if (sclFall && bitCntQ == BYTE_BITS) begin
            unique case (phaseQ)
              PH_ADDR: begin
                if (rxQ[7:1] == DEV_ADDR) begin
                  stateD = ST_ACK;
                  readD  = rxQ[0];
                end else begin
                  stateD = ST_IDLE;
                end
              end
              PH_SUB: begin
                if (subValid) begin
                  strb.loadSub = 1'b1;
                  stateD       = ST_ACK;
                end else begin
                  stateD = ST_IDLE;
                end
              end
              default: begin
                if (ptrInRange) begin
                  strb.writeData = 1'b1;
                  stateD         = ST_ACK;
                end else begin
                  stateD = ST_IDLE;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntD = '0;
            if (phaseQ == PH_ADDR && readQ) begin
              strb.loadRead = 1'b1;
              txD           = txByte;
              stateD        = ST_TX;
            end else begin
              stateD = ST_RX;
              phaseD = (phaseQ == PH_ADDR) ? PH_SUB : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCntQ == LAST_TX_BIT) begin
              stateD = ST_MACK;
            end else begin
              txD     = {txQ[6:0], 1'b0};
              bitCntD = bitCntQ + 4'd1;
            end
          end
        end
        default: begin
          if (sclRise) begin
            mAckD = ~sdaNow;
          end else if (sclFall) begin
            if (mAckQ) begin
              strb.loadRead = 1'b1;
              txD           = txByte;
              bitCntD       = '0;
              stateD        = ST_TX;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      phaseQ  <= PH_ADDR;
      bitCntQ <= '0;
      rxQ     <= '0;
      txQ     <= '1;
      readQ   <= 1'b0;
      mAckQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      phaseQ  <= phaseD;
      bitCntQ <= bitCntD;
      rxQ     <= rxD;
      txQ     <= txD;
      readQ   <= readD;
      mAckQ   <= mAckD;
    end
  end

  assign rxByte      = rxQ;
  assign sdaDriveLow = (stateQ == ST_ACK) | ((stateQ == ST_TX) & ~txQ[7]);

endmodule

// File: rtl/i2c_bank_regs.sv
module i2c_bank_regs
  import i2c_bank_pkg::*;
#(
  parameter int NUM_REGS  = 26,
  parameter int FREQ_BASE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strb,
  input  logic [7:0]  rxByte,
  output logic        subValid,
  output logic        ptrInRange,
  output logic [7:0]  txByte,
  output logic [31:0] freqWord
);

  localparam logic [7:0] TOP_SUB  = 8'(NUM_REGS - 1);
  localparam logic [7:0] FREQ_LO  = 8'(FREQ_BASE);
  localparam int         FREQ_LEN = 4;

  logic [7:0]  regQ [NUM_REGS];
  logic [7:0]  ptrQ;
  logic [2:0]  seqQ, seqD;
  logic [31:0] freqQ;
  logic [7:0]  rdIdx, freqOff;
  logic        inGroup, commit;
  logic [NUM_REGS-1:0] selVec;

  assign subValid   = rxByte <= TOP_SUB;
  assign ptrInRange = ptrQ <= TOP_SUB;
  assign rdIdx      = ptrInRange ? ptrQ : TOP_SUB;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSel
    assign selVec[g] = (rdIdx == 8'(g));
  end

  always_comb begin
    txByte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (selVec[i]) txByte |= regQ[i];
    end
  end

  // ordered-burst tracking for the frequency group
  assign freqOff = ptrQ - FREQ_LO;
  assign inGroup = (ptrQ >= FREQ_LO) && (freqOff < 8'(FREQ_LEN));

  always_comb begin
    seqD   = '0;
    commit = 1'b0;
    if (inGroup) begin
      if (freqOff == 8'd0) begin
        seqD = 3'd1;
      end else if (seqQ == freqOff[2:0]) begin
        if (freqOff == 8'(FREQ_LEN - 1)) commit = 1'b1;
        else                             seqD   = seqQ + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ  <= '0;
      seqQ  <= '0;
      freqQ <= '0;
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
    end else begin
      if (strb.busEvent) seqQ <= '0;
      if (strb.loadSub) begin
        ptrQ <= rxByte;
        seqQ <= '0;
      end
      if (strb.writeData) begin
        for (int i = 0; i < NUM_REGS; i++) begin
          if (ptrQ == 8'(i)) regQ[i] <= rxByte;
        end
        ptrQ <= ptrQ + 8'd1;
        seqQ <= seqD;
        if (commit) begin
          freqQ <= {rxByte, regQ[FREQ_BASE+2], regQ[FREQ_BASE+1], regQ[FREQ_BASE]};
        end
      end
      if (strb.loadRead && ptrInRange) ptrQ <= ptrQ + 8'd1;
    end
  end

  assign freqWord = freqQ;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         NUM_REGS  = 26,
  parameter int         FREQ_BASE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaDriveLow,
  output logic [31:0] freqWord
);

  bankStrobe_t strb;
  logic [7:0]  rxByte, txByte;
  logic        subValid, ptrInRange;

  i2c_bank_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .subValid   (subValid),
    .ptrInRange (ptrInRange),
    .txByte     (txByte),
    .rxByte     (rxByte),
    .strb       (strb),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_bank_regs #(.NUM_REGS(NUM_REGS), .FREQ_BASE(FREQ_BASE)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxByte    (rxByte),
    .subValid  (subValid),
    .ptrInRange(ptrInRange),
    .txByte    (txByte),
    .freqWord  (freqWord)
  );

endmodule

// File: rtl/i2c_bank_chk.sv
module i2c_bank_chk
  import i2c_bank_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaDriveLow,
  input logic [31:0] freqWord,
  input bankStrobe_t strb,
  input logic        subValid,
  input logic        ptrInRange
);

  AST_SUB_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSub |-> subValid); // R3

  AST_WRITE_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeData |-> ptrInRange); // R5

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadSub, strb.writeData, strb.loadRead})); // R2

  AST_FREQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (freqWord != $past(freqWord)) |-> $past(strb.writeData)); // R8

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !sclIn); // R11

endmodule

bind i2c_reg_bank i2c_bank_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .freqWord   (freqWord),
  .strb       (strb),
  .subValid   (subValid),
  .ptrInRange (ptrInRange)
);

// File: tb/sim_i2c_reg_bank.sv
module sim_i2c_reg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREG       = 26;
  localparam int FBASE      = 4;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaDriveLow;
  logic [31:0] freqWord;

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_reg_bank #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .FREQ_BASE(FBASE)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .sdaDriveLow(sdaDriveLow),
    .freqWord   (freqWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int holdOff = 0;

  // behavioural reference model
  logic [7:0]  mReg [NREG];
  int          mPtr = 0;
  int          burstQ[$];
  logic [31:0] expFreq = '0;
  logic [7:0]  txBuf[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic mSub(input logic [7:0] s);
    burstQ.delete();
    if (int'(s) < NREG) begin
      mPtr = int'(s);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic mWrite(input logic [7:0] b);
    int n;
    if (mPtr >= NREG) return 1'b0;
    mReg[mPtr] = b;
    burstQ.push_back(mPtr);
    n = burstQ.size();
    if (mPtr == FBASE + 3 && n >= 4 && burstQ[n-4] == FBASE && burstQ[n-3] == FBASE + 1
        && burstQ[n-2] == FBASE + 2) begin
      expFreq = {mReg[FBASE+3], mReg[FBASE+2], mReg[FBASE+1], mReg[FBASE]};
      holdOff = Q;
    end
    mPtr++;
    return 1'b1;
  endfunction

  function automatic logic [7:0] mRead();
    logic [7:0] v;
    v = mReg[(mPtr < NREG) ? mPtr : NREG - 1];
    if (mPtr < NREG) mPtr++;
    return v;
  endfunction

  // per-clock comparison against the model (R8, R9, R11)
  logic prevDrive = 1'b0;
  always begin
    @(posedge clk);
    #1;
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rstN) begin
      if (holdOff > 0) holdOff--;
      else check("R8/R9 freqWord vs model", freqWord, expFreq);
      if (sdaDriveLow !== prevDrive && sclM) check("R11 drive changed with SCL high", 1, 0);
    end
    prevDrive = sdaDriveLow;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
    burstQ.delete();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
    burstQ.delete();
  endtask

  task automatic clockBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
  endtask

  task automatic getAck(output logic ack);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    ack = ~sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclM = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      sclM = 1'b0;
    end
    waitQ();
    sdaM = hostAck ? 1'b0 : 1'b1; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  // address + pointer phase, leaves the bus in the data phase
  task automatic openWrite(input logic [7:0] sub, input string tag, output logic ok);
    logic a;
    logic ev;
    busStart();
    sendBits({DEV, 1'b0});
    getAck(a);
    check({tag, " R1 address ack"}, 32'(a), 1);
    sendBits(sub);
    ev = mSub(sub);
    getAck(a);
    check({tag, " R2/R3 pointer ack"}, 32'(a), 32'(ev));
    ok = ev;
  endtask

  task automatic writeTxn(input logic [7:0] sub, input string tag);
    logic ok;
    logic a;
    logic e;
    openWrite(sub, tag, ok);
    if (ok) begin
      foreach (txBuf[k]) begin
        sendBits(txBuf[k]);
        e = mWrite(txBuf[k]);
        getAck(a);
        check({tag, " R2/R5 data ack"}, 32'(a), 32'(e));
        if (!e) break;
      end
    end
    busStop();
  endtask

  task automatic readTxn(input logic [7:0] sub, input int n, input string tag);
    logic ok;
    logic a;
    logic [7:0] b;
    logic [7:0] exp;
    openWrite(sub, tag, ok);
    busStart();
    sendBits({DEV, 1'b1});
    getAck(a);
    check({tag, " R6 read address ack"}, 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      exp = mRead();
      check({tag, " R6/R7 read byte"}, 32'(b), 32'(exp));
    end
    waitQ();
    check({tag, " R7 released after host NACK"}, 32'(sdaDriveLow), 0);
    busStop();
  endtask

  initial begin
    logic a;
    logic ok;
    for (int i = 0; i < NREG; i++) mReg[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 SDA released after reset", 32'(sdaDriveLow), 0);
    check("R10 freqWord after reset", freqWord, 0);

    readTxn(8'd0, NREG, "R10 full readback");

    txBuf = {8'hA1, 8'hB2, 8'hC3};
    writeTxn(8'd10, "R2 burst");
    readTxn(8'd10, 3, "R6 burst readback");
    readTxn(8'd11, 1, "R6 single readback");

    // wrong device address
    busStart();
    sendBits({7'h13, 1'b0});
    getAck(a);
    check("R1 foreign address NACK", 32'(a), 0);
    sendBits(8'h03);
    getAck(a);
    check("R1 byte after foreign address ignored", 32'(a), 0);
    busStop();

    // invalid pointer, trailing byte must be ignored
    openWrite(8'(NREG), "R3 pointer at map size", ok);
    sendBits(8'h77);
    getAck(a);
    check("R3 trailing byte NACK", 32'(a), 0);
    busStop();
    openWrite(8'hF0, "R3 pointer far out", ok);
    busStop();

    // write past top of map
    txBuf = {8'h5C, 8'h6D, 8'h7E};
    writeTxn(8'(NREG - 2), "R5 write overrun");
    readTxn(8'(NREG - 2), 5, "R7 read overrun");

    // abort by repeated start in the middle of a byte
    openWrite(8'd12, "R4 abort start", ok);
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1);
    busStart();
    sendBits({DEV, 1'b0});
    getAck(a);
    check("R4 address accepted after abort", 32'(a), 1);
    busStop();
    // abort by stop in the middle of a byte
    openWrite(8'd12, "R4 abort stop", ok);
    clockBit(1'b1); clockBit(1'b1); clockBit(1'b1); clockBit(1'b0);
    busStop();
    readTxn(8'd12, 1, "R4 aborted register unchanged");

    // frequency group
    txBuf = {8'h11, 8'h22, 8'h33, 8'h44};
    writeTxn(8'(FBASE), "R8 ordered group");
    repeat (Q) @(negedge clk);
    check("R8 freqWord after ordered burst", freqWord, 32'h44332211);

    txBuf = {8'h55, 8'h66, 8'h77};
    writeTxn(8'(FBASE + 1), "R9 mid-group start");
    repeat (Q) @(negedge clk);
    check("R9 freqWord after mid-group burst", freqWord, 32'h44332211);

    txBuf = {8'h99};
    writeTxn(8'(FBASE), "R9 split part one");
    txBuf = {8'hAA, 8'hBB, 8'hCC};
    writeTxn(8'(FBASE + 1), "R9 split part two");
    repeat (Q) @(negedge clk);
    check("R9 freqWord after split transfers", freqWord, 32'h44332211);
    readTxn(8'(FBASE), 4, "R9 group registers still stored");

    txBuf = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    writeTxn(8'(FBASE - 2), "R8 burst through group");
    repeat (Q) @(negedge clk);
    check("R8 freqWord after pass-through burst", freqWord, 32'h06050403);

    readTxn(8'd0, NREG + 2, "R6 final readback");

    repeat (Q) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule